// File: doc/BRIEF.md
# Automatic XON/XOFF Flow Controller

This block makes the in-band (software) flow control decisions for one serial channel. On the receive side it watches the fill level of the receive FIFO. When the level climbs above an upper threshold, it asks the transmitter to send the XOFF character. When the level later drops below a lower threshold, it asks for the XON character. The gap between the two thresholds gives hysteresis, so a level that wobbles between them produces no extra control characters.

On the transmit side it watches every received character. A received XOFF pauses the local data transmitter and a received XON resumes it. An optional "resume on any" mode treats any character other than XOFF as a resume, and that character is still handed on to the receive holding buffer. The block also compares each received character with one programmable special character. It raises a sticky flag on a match, and a status read clears the flag.

The transmitter is driven through load strobes. The block issues a load only while the shifter reports it is ready, and never in the cycle that directly follows a load. A pending control character always wins over the next data byte. Control characters ignore the clear-to-send input.

Top module: `xonxoff_ctrl`

## Requirements
- R1: After a synchronous reset, `send_ctrl`, `send_data`, `store_valid`, `remote_off`, `local_paused` and `special_seen` are all 0.
- R2: With `tx_ib_en`=1, a receive level strictly greater than `upper_lvl` causes exactly one `send_ctrl` pulse with `ctrl_char`=`xoff_char`, and `remote_off` reads 1. A level equal to `upper_lvl` sends nothing. No further XOFF is sent until an XON has been sent.
- R3: After an XOFF, a level strictly below `lower_lvl` causes exactly one `send_ctrl` pulse with `ctrl_char`=`xon_char`, and `remote_off` returns to 0. A level equal to `lower_lvl`, or any level between the two thresholds, sends nothing.
- R4: Control characters are loaded regardless of `cts_ok`. A data load (`send_data`) requires `cts_ok`=1.
- R5: A load of either kind occurs only in a cycle after one where `tx_ready`=1 and no load was issued. When a control character is pending, it is loaded before any waiting data byte.
- R6: With `rx_ib_en`=1 and `xon_any`=0, a received `xoff_char` sets `local_paused`, and a received `xon_char` clears it. Neither character produces `store_valid`. While `local_paused`=1, no `send_data` occurs.
- R7: With `rx_ib_en`=1 and `xon_any`=1, a received `xoff_char` pauses and is consumed. Any other received character clears `local_paused` and is stored.
- R8: With `special_en`=1, a received `special_char` sets `special_seen` and is stored. A `stat_rd` pulse clears `special_seen`. A match in the same cycle as `stat_rd` leaves the flag set.
- R9: With `rx_ib_en`=0, every received character is stored and `local_paused` stays 0.
- R10: `store_valid` and `store_data` appear one clock after the `rx_valid` strobe that carried the character.
- R11: With `tx_ib_en`=0, no control characters are sent whatever the level, and `remote_off` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ib_en | input | 1 | Enable sending XON/XOFF from the receive level |
| rx_ib_en | input | 1 | Enable acting on received XON/XOFF |
| xon_any | input | 1 | Any received non-XOFF character resumes |
| special_en | input | 1 | Enable special character matching |
| xon_char | input | DATA_W | XON code |
| xoff_char | input | DATA_W | XOFF code |
| special_char | input | DATA_W | Special character code |
| upper_lvl | input | LVL_W | Upper receive level threshold |
| lower_lvl | input | LVL_W | Lower receive level threshold |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received character |
| store_valid | output | 1 | Character passed to receive holding buffer |
| store_data | output | DATA_W | Character passed on |
| tx_ready | input | 1 | Transmit shifter can take a character |
| data_avail | input | 1 | A data byte waits in the transmit FIFO |
| cts_ok | input | 1 | Clear-to-send is asserted |
| send_ctrl | output | 1 | Load pulse for a control character |
| ctrl_char | output | DATA_W | Control character to load |
| send_data | output | 1 | Load pulse for the next data byte |
| stat_rd | input | 1 | Status read strobe, clears special flag |
| remote_off | output | 1 | Remote transmitter was told XOFF |
| local_paused | output | 1 | Local transmitter paused by received XOFF |
| special_seen | output | 1 | Special character detected |

## Verification
The bench builds the block with its defaults, an 8-bit level and 8-bit characters. The thresholds are set at run time to 100 and 20. This makes it possible to drive levels exactly on each threshold and one step past it, and to see the hysteresis band in between. Directed sequences cover the single XOFF and XON per excursion, the priority of control characters over data, the idle cycle between loads, and the special flag when a match and a read fall in the same cycle. A seeded random run then mixes XON, XOFF, special and ordinary characters while the receive-enable and resume-on-any modes change. Each result is compared with a bench model of pause, store and flag state.

// File: rtl/xf_pkg.sv
package xf_pkg;
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_CTRL = 2'd1,
    LD_DATA = 2'd2
  } xf_load_e;
endpackage

// File: rtl/xf_level_track.sv
module xf_level_track #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] upper,
  input  logic [LVL_W-1:0] lower,
  output logic             want_off
);
  always_ff @(posedge clk) begin
    if (rst || !en) want_off <= 1'b0;
    else if (level > upper) want_off <= 1'b1;
    else if (level < lower) want_off <= 1'b0;
  end

  // R2: the stop request only rises after a level above the upper threshold
  p_rise_above_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(want_off) |-> $past(level > upper));
  // R3: the stop request only falls after a low level or a disable
  p_fall_below_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(want_off) |-> ($past(level < lower) || !$past(en)));
endmodule

// File: rtl/xf_tx_arb.sv
module xf_tx_arb
  import xf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              want_off,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic              tx_ready,
  input  logic              data_avail,
  input  logic              cts_ok,
  input  logic              paused,
  output logic              send_ctrl,
  output logic [DATA_W-1:0] ctrl_char,
  output logic              send_data,
  output logic              sent_off
);
  logic     pending;
  logic     can_load;
  xf_load_e pick;

  assign pending  = en && (want_off != sent_off);
  assign can_load = tx_ready && !send_ctrl && !send_data;

  always_comb begin
    pick = LD_NONE;
    if (can_load) begin
      if (pending) pick = LD_CTRL;
      else if (data_avail && !paused && cts_ok) pick = LD_DATA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      send_ctrl <= 1'b0;
      send_data <= 1'b0;
      ctrl_char <= '0;
      sent_off  <= 1'b0;
    end else begin
      send_ctrl <= (pick == LD_CTRL);
      send_data <= (pick == LD_DATA);
      if (!en) sent_off <= 1'b0;
      else if (pick == LD_CTRL) begin
        sent_off  <= want_off;
        ctrl_char <= want_off ? xoff_char : xon_char;
      end
    end
  end

  // R5: loads are separated by at least one idle cycle
  p_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (send_ctrl || send_data) |=> !(send_ctrl || send_data));
  // R5: a load follows a ready shifter
  p_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (send_ctrl || send_data) |-> $past(tx_ready));
  // R4 and R6: data needs clear-to-send and no pause
  p_data_gate_r6: assert property (@(posedge clk) disable iff (rst)
    send_data |-> ($past(cts_ok) && !$past(paused)));
  // R11: nothing is sent while in-band sending is off
  p_off_r11: assert property (@(posedge clk) disable iff (rst)
    send_ctrl |-> $past(en));
endmodule

// File: rtl/xf_rx_match.sv
module xf_rx_match #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              xon_any,
  input  logic              special_en,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic [DATA_W-1:0] special_char,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              stat_rd,
  output logic              store_valid,
  output logic [DATA_W-1:0] store_data,
  output logic              paused,
  output logic              special_seen
);
  logic is_xon, is_xoff, is_special, consume;

  assign is_xon     = (rx_data == xon_char);
  assign is_xoff    = (rx_data == xoff_char);
  assign is_special = special_en && (rx_data == special_char);
  assign consume    = en && (is_xoff || (is_xon && !xon_any));

  always_ff @(posedge clk) begin
    if (rst) begin
      store_valid  <= 1'b0;
      store_data   <= '0;
      paused       <= 1'b0;
      special_seen <= 1'b0;
    end else begin
      store_valid <= rx_valid && !consume;
      if (rx_valid) store_data <= rx_data;
      if (!en) paused <= 1'b0;
      else if (rx_valid) begin
        if (is_xoff) paused <= 1'b1;
        else if (is_xon || xon_any) paused <= 1'b0;
      end
      if (rx_valid && is_special) special_seen <= 1'b1;
      else if (stat_rd) special_seen <= 1'b0;
    end
  end

  // R6: a received XOFF under matching never reaches the holding buffer
  p_xoff_consumed_r6: assert property (@(posedge clk) disable iff (rst)
    store_valid |-> !($past(en) && ($past(rx_data) == $past(xoff_char))));
  // R10: a store always follows a receive strobe
  p_store_lat_r10: assert property (@(posedge clk) disable iff (rst)
    store_valid |-> $past(rx_valid));
  // R9: no pause while matching is off
  p_no_pause_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !paused);
  // R8: the flag only rises on a matching receive
  p_special_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(special_seen) |-> ($past(rx_valid) && $past(special_en)));
endmodule

// File: rtl/xonxoff_ctrl.sv
module xonxoff_ctrl #(
  parameter int LVL_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_ib_en,
  input  logic              rx_ib_en,
  input  logic              xon_any,
  input  logic              special_en,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic [DATA_W-1:0] special_char,
  input  logic [LVL_W-1:0]  upper_lvl,
  input  logic [LVL_W-1:0]  lower_lvl,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              store_valid,
  output logic [DATA_W-1:0] store_data,
  input  logic              tx_ready,
  input  logic              data_avail,
  input  logic              cts_ok,
  output logic              send_ctrl,
  output logic [DATA_W-1:0] ctrl_char,
  output logic              send_data,
  input  logic              stat_rd,
  output logic              remote_off,
  output logic              local_paused,
  output logic              special_seen
);
  logic want_off;

  xf_level_track #(.LVL_W(LVL_W)) u_lvl (
    .clk(clk), .rst(rst), .en(tx_ib_en), .level(rx_level),
    .upper(upper_lvl), .lower(lower_lvl), .want_off(want_off)
  );

  xf_rx_match #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .en(rx_ib_en), .xon_any(xon_any),
    .special_en(special_en), .xon_char(xon_char), .xoff_char(xoff_char),
    .special_char(special_char), .rx_valid(rx_valid), .rx_data(rx_data),
    .stat_rd(stat_rd), .store_valid(store_valid), .store_data(store_data),
    .paused(local_paused), .special_seen(special_seen)
  );

  xf_tx_arb #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .en(tx_ib_en), .want_off(want_off),
    .xon_char(xon_char), .xoff_char(xoff_char), .tx_ready(tx_ready),
    .data_avail(data_avail), .cts_ok(cts_ok), .paused(local_paused),
    .send_ctrl(send_ctrl), .ctrl_char(ctrl_char), .send_data(send_data),
    .sent_off(remote_off)
  );

  // R1: outputs are quiet in the cycle after reset
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !(send_ctrl || send_data || store_valid || remote_off));
endmodule

// File: tb/xonxoff_ctrl_test.sv
module xonxoff_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] XON = 8'h11, XOFF = 8'h13, SPC = 8'h7E;

  logic clk = 0, rst = 1;
  logic tx_ib_en = 0, rx_ib_en = 0, xon_any = 0, special_en = 0;
  logic [7:0] xon_char = XON, xoff_char = XOFF, special_char = SPC;
  logic [7:0] upper_lvl = 8'd100, lower_lvl = 8'd20, rx_level = 0;
  logic rx_valid = 0; logic [7:0] rx_data = 0;
  logic store_valid; logic [7:0] store_data;
  logic tx_ready = 1, data_avail = 0, cts_ok = 0;
  logic send_ctrl, send_data; logic [7:0] ctrl_char;
  logic stat_rd = 0, remote_off, local_paused, special_seen;

  int checks = 0, errors = 0, ctrl_cnt = 0, data_cnt = 0;
  logic [7:0] last_ctrl = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xonxoff_ctrl uut (.*);

  always @(negedge clk) begin
    if (send_ctrl) begin ctrl_cnt++; last_ctrl = ctrl_char; end
    if (send_data) data_cnt++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rx_char(logic [7:0] c, logic rd);
    @(negedge clk); rx_valid = 1; rx_data = c; stat_rd = rd;
    @(posedge clk); #1;
    @(negedge clk); rx_valid = 0; stat_rd = 0;
  endtask

  function automatic bit exp_store(bit en, bit any, logic [7:0] c);
    if (!en) return 1;
    if (c == XOFF) return 0;
    if (c == XON && !any) return 0;
    return 1;
  endfunction

  function automatic bit exp_pause(bit en, bit any, logic [7:0] c, bit cur);
    if (!en) return 0;
    if (c == XOFF) return 1;
    if (c == XON || any) return 0;
    return cur;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, d0;
    bit pexp, sexp;
    void'($urandom(32'd1234));
    cyc(3);
    check("R1 send_ctrl", send_ctrl, 0);
    check("R1 send_data", send_data, 0);
    check("R1 remote_off", remote_off, 0);
    check("R1 paused", local_paused, 0);
    check("R1 special", special_seen, 0);
    check("R1 store", store_valid, 0);
    @(negedge clk); rst = 0; tx_ib_en = 1; rx_ib_en = 1; special_en = 1;

    // R2: level on threshold sends nothing; one step above sends XOFF without CTS (R4)
    @(negedge clk); rx_level = 100; cyc(4);
    check("R2 equal upper", ctrl_cnt, 0);
    @(negedge clk); rx_level = 101; cyc(4);
    check("R2/R4 xoff count", ctrl_cnt, 1);
    check("R2 xoff char", last_ctrl, XOFF);
    check("R2 remote_off", remote_off, 1);
    @(negedge clk); rx_level = 120; cyc(3);
    @(negedge clk); rx_level = 60; cyc(3);
    @(negedge clk); rx_level = 20; cyc(3);
    check("R3 hysteresis", ctrl_cnt, 1);
    @(negedge clk); rx_level = 19; cyc(4);
    check("R3 xon count", ctrl_cnt, 2);
    check("R3 xon char", last_ctrl, XON);
    check("R3 remote_off", remote_off, 0);

    // R5: priority and gap
    @(negedge clk); tx_ready = 0; data_avail = 1; cts_ok = 1; rx_level = 150; cyc(3);
    check("R5 wait ready ctrl", ctrl_cnt, 2);
    check("R5 wait ready data", data_cnt, 0);
    @(negedge clk); tx_ready = 1; cyc(1);
    check("R5 ctrl first", send_ctrl, 1);
    check("R5 no data with ctrl", send_data, 0);
    cyc(1);
    check("R5 gap", send_data, 0);
    cyc(1);
    check("R5 data next", send_data, 1);
    @(negedge clk); data_avail = 0; rx_level = 0; cyc(4);
    check("R3 xon after", remote_off, 0);

    // R6: received XOFF/XON consumed, pauses data
    rx_char(XOFF, 0);
    check("R6 xoff stored", store_valid, 0);
    check("R6 paused", local_paused, 1);
    d0 = data_cnt;
    @(negedge clk); data_avail = 1; cyc(4);
    check("R6 no data paused", data_cnt, d0);
    rx_char(XON, 0);
    check("R6 xon stored", store_valid, 0);
    check("R6 resumed", local_paused, 0);
    cyc(3);
    check("R6 data flows", (data_cnt > d0) ? 1 : 0, 1);
    @(negedge clk); data_avail = 0;

    // R9 and R10
    @(negedge clk); rx_ib_en = 0;
    rx_char(XOFF, 0);
    check("R9/R10 stored", store_valid, 1);
    check("R10 data", store_data, XOFF);
    check("R9 no pause", local_paused, 0);

    // R8
    rx_char(SPC, 0);
    check("R8 stored", store_valid, 1);
    check("R8 flag set", special_seen, 1);
    @(negedge clk); stat_rd = 1; cyc(1); @(negedge clk); stat_rd = 0;
    check("R8 cleared", special_seen, 0);
    rx_char(SPC, 1);
    check("R8 set wins", special_seen, 1);

    // R7
    @(negedge clk); rx_ib_en = 1; xon_any = 1;
    rx_char(XOFF, 0);
    check("R7 xoff paused", local_paused, 1);
    check("R7 xoff consumed", store_valid, 0);
    rx_char(8'h41, 0);
    check("R7 any resumes", local_paused, 0);
    check("R7 any stored", store_valid, 1);

    // R11
    @(negedge clk); tx_ib_en = 0; c0 = ctrl_cnt; rx_level = 200; cyc(5);
    check("R11 no ctrl", ctrl_cnt, c0);
    check("R11 remote_off", remote_off, 0);

    // random receive traffic
    @(negedge clk); stat_rd = 1; cyc(1);
    @(negedge clk); stat_rd = 0;
    pexp = local_paused; sexp = 0;
    for (int i = 0; i < 300; i++) begin
      logic [7:0] c;
      bit en, any, rd;
      int k;
      k = $urandom_range(0, 3);
      c = (k == 0) ? XON : (k == 1) ? XOFF : (k == 2) ? SPC : 8'($urandom_range(32, 90));
      en = $urandom_range(0, 3) != 0;
      any = $urandom_range(0, 1);
      rd = $urandom_range(0, 4) == 0;
      @(negedge clk);
      rx_ib_en = en; xon_any = any; rx_valid = 1; rx_data = c; stat_rd = rd;
      @(posedge clk); #1;
      pexp = exp_pause(en, any, c, pexp);
      sexp = (c == SPC) ? 1 : (rd ? 0 : sexp);
      check("R6/R7/R9 rand store", store_valid, exp_store(en, any, c));
      check("R6/R7/R9 rand pause", local_paused, pexp);
      check("R8 rand special", special_seen, sexp);
    end
    @(negedge clk); rx_valid = 0; stat_rd = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule